// File: doc/BRIEF.md
# Sliding Window Fan-Out Buffer

This block sits between a memory stream and a row of identical compute lanes. It takes array elements in beats of several words. It reads every element exactly once and turns the stream into overlapping windows of consecutive elements, one window per lane. On each cycle that it advances, lane `i` receives the window that starts at element `LANES*beat + i`. The start points of all lanes therefore step forward by `LANES` from one output beat to the next, and the lanes receive a full set of new windows every cycle.

The block keeps one input beat in a hold register. When the following beat arrives, it has every element needed for the windows that begin inside the held beat. With the default sizes this covers 8 lanes, windows of 4 elements and 20 windows. The array is 23 elements long and is consumed as 3 input beats, where window-by-window fetching would take 80 reads. A scheduler starts each run with a one-cycle enable. The block asserts a one-cycle done pulse after the final window beat has been taken. It then waits for the next enable.

Top module: `sbuf_top`

## Requirements
- R1: After reset, and whenever reset is asserted during a run, `in_ready`, `win_valid` and `done` are low, and the block waits idle for a start.
- R2: While idle, no input beat is accepted (`in_ready` low) until `start` is high for a cycle. A `start` during a run has no effect on the windows produced.
- R3: Input word `j` of a beat sits at `in_data[j*DW +: DW]`. Lane `i` tap `t` of the output sits at `win_data[(i*WIN+t)*DW +: DW]`. For output beat `b` it equals array element `b*LANES+i+t`. No windows are presented in the cycle after the first input beat is accepted.
- R4: Successive output beats advance every lane's start element by exactly `LANES`.
- R5: A run accepts exactly `ceil((NUM_WIN+WIN-1)/LANES)` input beats, so every element is read once. After that, `in_ready` stays low.
- R6: `lane_mask[i]` is high exactly when `b*LANES+i < NUM_WIN`. A final beat whose windows fall short of `LANES` carries a partial mask. When the last input beat already holds every element of the last windows, that output beat is issued without a further input beat.
- R7: While `win_valid` is high and `out_ready` is low, `win_valid`, `win_data` and `lane_mask` hold, and `in_ready` is low. No element is lost or repeated.
- R8: `done` is high for exactly one cycle, in the cycle after the final output beat is accepted. The block is then idle again and accepts a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run enable from the scheduler |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle when high together with in_valid |
| in_data | input | LANES*DW | Input beat of consecutive array words |
| win_valid | output | 1 | Window beat valid |
| out_ready | input | 1 | Lanes take the window beat |
| win_data | output | LANES*WIN*DW | One window per lane |
| lane_mask | output | LANES | Per-lane window valid |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two events can land on the same edge: an output beat is taken, and the next input beat is accepted and turns into a new output beat. Both hang on `out_ready`, because an input beat is only admitted when the output register will be free. The bench drives `out_ready` from several per-cycle patterns. Some cycles therefore take and refill at once, and others stall with input pending. Each taken beat is compared with windows computed from the array index. This confirms that no beat was skipped, repeated or overwritten while it was still waiting.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} run_st_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int WIN     = 4,
  parameter int NUM_WIN = 20,
  localparam int IN_BEATS  = cdiv(NUM_WIN + WIN - 1, LANES),
  localparam int OUT_BEATS = cdiv(NUM_WIN, LANES),
  localparam int CW        = $clog2(IN_BEATS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          load_hold,
  output logic          load_nxt,
  output logic          produce,
  output logic [CW-1:0] beat_idx,
  output logic          out_valid,
  output logic          done
);
  localparam logic [CW-1:0] IB_C = CW'(IN_BEATS);
  localparam logic [CW-1:0] OB_C = CW'(OUT_BEATS);

  run_st_e       st_q, st_d;
  logic [CW-1:0] in_cnt_q, in_cnt_d, out_cnt_q, out_cnt_d;
  logic          vld_q, vld_d, done_q, done_d;
  logic          running, slot_free, in_fire, flush, last_take, kick;

  always_comb begin
    running   = (st_q == ST_RUN);
    slot_free = !vld_q || out_ready;
    in_ready  = running && (in_cnt_q < IB_C) && ((in_cnt_q == '0) || slot_free);
    in_fire   = in_valid && in_ready;
    flush     = running && (in_cnt_q == IB_C) && (out_cnt_q < OB_C) && slot_free;
    produce   = (in_fire && (in_cnt_q != '0)) || flush;
    last_take = vld_q && out_ready && (out_cnt_q == OB_C);
    kick      = (st_q == ST_IDLE) && start;

    st_d      = st_q;
    in_cnt_d  = in_cnt_q;
    out_cnt_d = out_cnt_q;
    if (kick) begin
      st_d      = ST_RUN;
      in_cnt_d  = '0;
      out_cnt_d = '0;
    end else begin
      if (last_take) st_d = ST_IDLE;
      if (in_fire)   in_cnt_d  = in_cnt_q + 1'b1;
      if (produce)   out_cnt_d = out_cnt_q + 1'b1;
    end
    vld_d  = produce ? 1'b1 : (out_ready ? 1'b0 : vld_q);
    done_d = last_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      in_cnt_q  <= '0;
      out_cnt_q <= '0;
      vld_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      in_cnt_q  <= in_cnt_d;
      out_cnt_q <= out_cnt_d;
      vld_q     <= vld_d;
      done_q    <= done_d;
    end
  end

  assign load_hold = in_fire;
  assign load_nxt  = in_fire && (in_cnt_q != '0);
  assign beat_idx  = out_cnt_q;
  assign out_valid = vld_q;
  assign done      = done_q;

  p_idle_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !in_ready);
  p_first_no_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_cnt_q == '0) |=> !out_valid);
  p_in_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt_q == IB_C) |-> !in_ready);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/sbuf_window_net.sv
module sbuf_window_net #(
  parameter int DW      = 16,
  parameter int LANES   = 8,
  parameter int WIN     = 4,
  parameter int NUM_WIN = 20,
  parameter int CW      = 2,
  localparam int EXT    = LANES + WIN - 1
) (
  input  logic [LANES*DW-1:0]     hold,
  input  logic [(WIN-1)*DW-1:0]   nxt,
  input  logic [CW-1:0]           beat_idx,
  output logic [LANES*WIN*DW-1:0] win,
  output logic [LANES-1:0]        mask
);
  logic [EXT*DW-1:0] ext;
  assign ext = {nxt, hold};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    for (genvar t = 0; t < WIN; t++) begin : g_tap
      assign win[(i*WIN+t)*DW +: DW] = ext[(i+t)*DW +: DW];
    end
    assign mask[i] = (int'(beat_idx) * LANES + i) < NUM_WIN;
  end
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top
  import sbuf_pkg::*;
#(
  parameter int DW      = 16,
  parameter int LANES   = 8,
  parameter int WIN     = 4,
  parameter int NUM_WIN = 20,
  localparam int CW     = $clog2(cdiv(NUM_WIN + WIN - 1, LANES) + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LANES*DW-1:0]     in_data,
  output logic                    win_valid,
  input  logic                    out_ready,
  output logic [LANES*WIN*DW-1:0] win_data,
  output logic [LANES-1:0]        lane_mask,
  output logic                    done
);
  logic                    load_hold, load_nxt, produce;
  logic [CW-1:0]           beat_idx;
  logic [LANES*DW-1:0]     hold_q;
  logic [(WIN-1)*DW-1:0]   nxt;
  logic [LANES*WIN*DW-1:0] win_d, win_q;
  logic [LANES-1:0]        mask_d, mask_q;

  sbuf_ctrl #(.LANES(LANES), .WIN(WIN), .NUM_WIN(NUM_WIN)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .out_ready(out_ready), .in_ready(in_ready), .load_hold(load_hold),
    .load_nxt(load_nxt), .produce(produce), .beat_idx(beat_idx),
    .out_valid(win_valid), .done(done)
  );

  assign nxt = load_nxt ? in_data[(WIN-1)*DW-1:0] : '0;

  sbuf_window_net #(.DW(DW), .LANES(LANES), .WIN(WIN), .NUM_WIN(NUM_WIN), .CW(CW)) net_i (
    .hold(hold_q), .nxt(nxt), .beat_idx(beat_idx), .win(win_d), .mask(mask_d)
  );

  always_ff @(posedge clk) begin
    if (load_hold) hold_q <= in_data;
    if (produce) begin
      win_q  <= win_d;
      mask_q <= mask_d;
    end
  end

  assign win_data  = win_q;
  assign lane_mask = mask_q;

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !out_ready) |=> (win_valid && $stable(win_data) && $stable(lane_mask)));
  p_stall_noin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !out_ready) |-> !in_ready);
  p_mask_lane0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> lane_mask[0]);
  p_mask_prefix_r6: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> $onehot0(lane_mask + 1'b1));
endmodule

// File: tb/sbuf_top_tb_top.sv
module sbuf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int L  = 8;
  localparam int WN = 4;
  localparam int WW = L * WN * DW;

  // row fields: {sel, mid_start, pattern[15:0], base[15:0]}
  localparam logic [33:0] VEC [5] = '{
    {1'b0, 1'b0, 16'hFFFF, 16'h0100},
    {1'b0, 1'b1, 16'hAAAA, 16'h2000},
    {1'b1, 1'b0, 16'hFFFF, 16'h0A00},
    {1'b1, 1'b1, 16'h3C3C, 16'h7FF0},
    {1'b0, 1'b0, 16'h9249, 16'h4321}
  };

  logic clk, rst_n, start, in_valid, out_ready, sel;
  logic [L*DW-1:0] in_data;
  logic a_in_ready, a_win_valid, a_done, b_in_ready, b_win_valid, b_done;
  logic [WW-1:0] a_win, b_win;
  logic [L-1:0]  a_mask, b_mask;
  logic in_ready, win_valid, done;
  logic [WW-1:0] win_data;
  logic [L-1:0]  lane_mask;
  int n_tests, n_fail;

  sbuf_top #(.DW(DW), .LANES(L), .WIN(WN), .NUM_WIN(20)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start && !sel), .in_valid(in_valid && !sel),
    .in_ready(a_in_ready), .in_data(in_data), .win_valid(a_win_valid),
    .out_ready(out_ready), .win_data(a_win), .lane_mask(a_mask), .done(a_done)
  );
  sbuf_top #(.DW(DW), .LANES(L), .WIN(WN), .NUM_WIN(16)) dut16_i (
    .clk(clk), .rst_n(rst_n), .start(start && sel), .in_valid(in_valid && sel),
    .in_ready(b_in_ready), .in_data(in_data), .win_valid(b_win_valid),
    .out_ready(out_ready), .win_data(b_win), .lane_mask(b_mask), .done(b_done)
  );

  assign in_ready  = sel ? b_in_ready  : a_in_ready;
  assign win_valid = sel ? b_win_valid : a_win_valid;
  assign done      = sel ? b_done      : a_done;
  assign win_data  = sel ? b_win       : a_win;
  assign lane_mask = sel ? b_mask      : a_mask;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [L*DW-1:0] beat_words(input logic [15:0] base, input int ib);
    logic [L*DW-1:0] v;
    for (int j = 0; j < L; j++) v[j*DW +: DW] = base + 16'(ib*L + j);
    return v;
  endfunction

  task automatic run_row(input bit s, input bit mid, input logic [15:0] pat, input logic [15:0] base);
    int nw, ibeats, obeats, ib, ob, cyc;
    bit stall_prev, first_chk;
    logic [WW-1:0] prev, expw;
    logic [L-1:0] expm;
    nw = s ? 16 : 20;
    ibeats = (nw + WN - 1 + L - 1) / L;
    obeats = (nw + L - 1) / L;
    ib = 0; ob = 0; cyc = 0; stall_prev = 0; first_chk = 0;
    sel = s;
    @(negedge clk); start = 1'b1; in_valid = 1'b0;
    @(negedge clk); start = 1'b0;
    while (ob < obeats && cyc < 400) begin
      if (cyc != 0) @(negedge clk);
      if (stall_prev) chk(win_valid && win_data == prev, "R7 held beat", win_data, prev);
      if (first_chk) begin
        chk(!win_valid, "R3 no window after first beat", WW'(win_valid), '0);
        first_chk = 0;
      end
      out_ready = pat[cyc % 16];
      in_valid  = (ib < ibeats);
      in_data   = beat_words(base, ib);
      start     = mid && (cyc == 3);
      #1;
      if (win_valid && !out_ready) begin
        chk(!in_ready, "R7 ready low in stall", WW'(in_ready), '0);
        stall_prev = 1; prev = win_data;
      end else stall_prev = 0;
      if (win_valid && out_ready) begin
        expw = '0;
        for (int i = 0; i < L; i++) begin
          expm[i] = (ob*L + i) < nw;
          for (int t = 0; t < WN; t++)
            if (expm[i]) expw[(i*WN+t)*DW +: DW] = base + 16'(ob*L + i + t);
        end
        for (int i = 0; i < L; i++)
          if (!expm[i]) for (int t = 0; t < WN; t++) expw[(i*WN+t)*DW +: DW] = win_data[(i*WN+t)*DW +: DW];
        chk(lane_mask == expm, "R6 lane mask", WW'(lane_mask), WW'(expm));
        chk(win_data == expw, "R3 R4 window contents", win_data, expw);
        ob++;
      end
      if (in_valid && in_ready) begin
        if (ib == 0) first_chk = 1;
        ib++;
      end
      cyc++;
    end
    @(negedge clk);
    start = 1'b0; in_valid = 1'b1; out_ready = 1'b1;
    #1;
    chk(done, "R8 done after last beat", WW'(done), WW'(1));
    chk(ib == ibeats, "R5 input beat count", WW'(ib), WW'(ibeats));
    chk(!in_ready, "R5 no further input", WW'(in_ready), '0);
    @(negedge clk); #1;
    chk(!done, "R8 done one cycle", WW'(done), '0);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    sel = 0; start = 0; in_valid = 0; out_ready = 0; in_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!in_ready && !win_valid && !done, "R1 reset state", WW'({in_ready, win_valid, done}), '0);
    rst_n = 1'b1;
    // R2: idle ignores input until start
    in_valid = 1'b1; in_data = beat_words(16'h0, 0);
    repeat (4) begin
      @(negedge clk); #1;
      chk(!in_ready, "R2 idle blocks input", WW'(in_ready), '0);
    end
    in_valid = 1'b0;
    // table walk
    for (int r = 0; r < 5; r++)
      run_row(VEC[r][33], VEC[r][32], VEC[r][31:16], VEC[r][15:0]);
    // R1: reset during a run
    sel = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; in_valid = 1'b1; out_ready = 1'b0;
    in_data = beat_words(16'h0, 0);
    @(negedge clk); in_data = beat_words(16'h0, 1);
    @(negedge clk); in_valid = 1'b0;
    #1;
    chk(win_valid, "R7 beat pending before reset", WW'(win_valid), WW'(1));
    rst_n = 1'b0; #1;
    chk(!in_ready && !win_valid && !done, "R1 reset mid-run", WW'({in_ready, win_valid, done}), '0);
    @(negedge clk); rst_n = 1'b1;
    // R8: a new run after recovery
    run_row(1'b0, 1'b0, 16'h7777, 16'h1234);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule